// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the registers of a type-1 (bridge) configuration header that belong to the bridge function itself. It stores the bus number registers, the secondary latency timer, the I/O, memory and prefetchable window registers with their upper extensions, and the bridge control word. It also returns fixed identity and capability values: the bridge class code, the bridge header type and the status capability bits. Configuration accesses arrive on a simple port. Each access carries a dword index and four byte enables. A read returns its data one cycle after the request.

Two single-cycle strobes come out of the block. `win_update` pulses after any write whose enabled bytes overlap a register that affects downstream address decoding. `sec_bus_rst` pulses once when software sets the secondary bus reset control bit, bit 6 of bridge control, from 0 to 1. A three-state machine produces the reset pulse:
- `SR_IDLE`: the bit is clear.
- `SR_PULSE`: the bit has just risen, and the pulse is driven.
- `SR_HOLD`: the bit stays set, and nothing is driven.

The machine moves as follows:
- `SR_IDLE` goes to `SR_PULSE` on a write that sets the bit.
- `SR_PULSE` goes to `SR_HOLD` if the bit stays set, or back to `SR_IDLE` if it is cleared.
- `SR_HOLD` goes to `SR_IDLE` when a write clears the bit.

Parameters select the following:
- 32-bit I/O decode.
- 64-bit prefetchable decode.
- The multifunction flag.
- Whether reset leaves every window closed (forwarding off) or zeroed.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset, dword 0x18 (primary, secondary, subordinate bus, secondary latency timer in bytes 0..3) reads 0.
- R2: Reset with FWD_OFF_AT_RESET=0 clears the address range bits of all windows. The read-only type nibbles keep their values: I/O base and limit low nibble = 1 when IO_32BIT else 0, memory = 0, prefetchable = 1 when PREF_64BIT else 0. Both prefetchable upper dwords (0x28, 0x2C), I/O upper (0x30) and bridge control (0x3E) read 0.
- R3: With FWD_OFF_AT_RESET=1, reset sets all range bits of every base register and clears all range bits of every limit register. For example, memory dword 0x20 reads 0x0000FFF0, and the upper registers read 0.
- R4: A write changes only the bytes whose enable is set. The low nibble of every base/limit byte pair is read-only.
- R5: Prefetchable upper registers are writable only when PREF_64BIT=1, and the I/O upper register only when IO_32BIT=1. Otherwise they read 0.
- R6: `sec_bus_rst` is high for exactly one cycle, in the cycle after a write that moves bridge control bit 6 (write data bit 22 at dword 0x3C, byte 2) from 0 to 1. Writing 1 when the bit is already 1, or writing with byte 2 disabled, gives no pulse.
- R7: `win_update` is high for one cycle after a write whose enabled bytes overlap any of these: command (0x04-0x05), I/O base/limit (0x1C-0x1D), 0x20-0x33, or bridge control (0x3E-0x3F). Writes to other bytes give no pulse.
- R8: Dword 0x08 reads 0x06040000 (class bridge, revision 0). Dword 0x0C reads header type 0x01 in byte 2, with bit 7 of that byte equal to MULTI_FUNC. Writes do not change them.
- R9: Primary status (0x06) and secondary status (0x1E) both read 0x00A0 (66 MHz capable bit 5, fast back-to-back bit 7) and ignore writes.
- R10: A read returns data with `cfg_rvalid` high in the next cycle. Unimplemented dwords read 0.
- R11: Reads never raise `win_update` or `sec_bus_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Access request, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| win_update | output | 1 | Decode-affecting write occurred |
| sec_bus_rst | output | 1 | Secondary bus reset pulse |

## Verification
The bench builds two instances on a shared access port:
- `u_dut` uses the defaults: 32-bit I/O, 64-bit prefetchable, single function, zeroed windows at reset.
- `u_dut_alt` uses 16-bit I/O, 32-bit prefetchable, multifunction, and forwarding off at reset.

The default instance reaches the writable upper registers and the type nibble value 1. The alternate instance reaches the closed-window reset values, the upper registers tied to zero, the type nibble value 0 and the multifunction header bit. Both instances see identical stimulus, so every write is checked against both variants at once.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int DW_AW = 6;

    localparam logic [DW_AW-1:0] DW_CMDSTS  = 6'd1;
    localparam logic [DW_AW-1:0] DW_CLASS   = 6'd2;
    localparam logic [DW_AW-1:0] DW_HDR     = 6'd3;
    localparam logic [DW_AW-1:0] DW_BUSNUM  = 6'd6;
    localparam logic [DW_AW-1:0] DW_IOSTS   = 6'd7;
    localparam logic [DW_AW-1:0] DW_MEM     = 6'd8;
    localparam logic [DW_AW-1:0] DW_PREF    = 6'd9;
    localparam logic [DW_AW-1:0] DW_PREF_UB = 6'd10;
    localparam logic [DW_AW-1:0] DW_PREF_UL = 6'd11;
    localparam logic [DW_AW-1:0] DW_IO_UP   = 6'd12;
    localparam logic [DW_AW-1:0] DW_BRCTL   = 6'd15;

    localparam logic [15:0] STATUS_CAPS = 16'h00A0;
    localparam logic [23:0] CLASS_P2P   = 24'h060400;
    localparam logic [6:0]  HDR_BRIDGE  = 7'h01;
    localparam int          SRST_BIT    = 6;

    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_PULSE = 2'd1,
        SR_HOLD  = 2'd2
    } srst_state_e;

    // byte write enables, only for bytes that hold storage
    typedef struct packed {
        logic [3:0] bus;
        logic [1:0] io;
        logic [3:0] mem;
        logic [3:0] pref;
        logic [3:0] pref_ub;
        logic [3:0] pref_ul;
        logic [3:0] io_up;
        logic [1:0] brctl;
    } bcfg_we_t;

    typedef struct packed {
        logic [7:0]  pri_bus;
        logic [7:0]  sec_bus;
        logic [7:0]  sub_bus;
        logic [7:0]  sec_lat;
        logic [3:0]  io_base_rng;
        logic [3:0]  io_lim_rng;
        logic [11:0] mem_base_rng;
        logic [11:0] mem_lim_rng;
        logic [11:0] pref_base_rng;
        logic [11:0] pref_lim_rng;
        logic [31:0] pref_base_up;
        logic [31:0] pref_lim_up;
        logic [15:0] io_base_up;
        logic [15:0] io_lim_up;
        logic [15:0] brctl;
    } bcfg_regs_t;

endpackage

// File: rtl/bcfg_wr_decode.sv
module bcfg_wr_decode
    import bcfg_pkg::*;
(
    input  logic             cfg_req,
    input  logic             cfg_we,
    input  logic [DW_AW-1:0] cfg_addr,
    input  logic [3:0]       cfg_be,
    output bcfg_we_t         we,
    output logic             win_hit
);

    logic wr;
    assign wr = cfg_req && cfg_we;

    always_comb begin
        we         = '0;
        we.bus     = (wr && cfg_addr == DW_BUSNUM)  ? cfg_be       : 4'b0;
        we.io      = (wr && cfg_addr == DW_IOSTS)   ? cfg_be[1:0]  : 2'b0;
        we.mem     = (wr && cfg_addr == DW_MEM)     ? cfg_be       : 4'b0;
        we.pref    = (wr && cfg_addr == DW_PREF)    ? cfg_be       : 4'b0;
        we.pref_ub = (wr && cfg_addr == DW_PREF_UB) ? cfg_be       : 4'b0;
        we.pref_ul = (wr && cfg_addr == DW_PREF_UL) ? cfg_be       : 4'b0;
        we.io_up   = (wr && cfg_addr == DW_IO_UP)   ? cfg_be       : 4'b0;
        we.brctl   = (wr && cfg_addr == DW_BRCTL)   ? cfg_be[3:2]  : 2'b0;
    end

    // byte-range overlap with decode-affecting registers
    always_comb begin
        win_hit = 1'b0;
        if (wr) begin
            if (cfg_addr == DW_CMDSTS && |cfg_be[1:0])                 win_hit = 1'b1;
            if (cfg_addr == DW_IOSTS && |cfg_be[1:0])                  win_hit = 1'b1;
            if (cfg_addr >= DW_MEM && cfg_addr <= DW_IO_UP && |cfg_be) win_hit = 1'b1;
            if (cfg_addr == DW_BRCTL && |cfg_be[3:2])                  win_hit = 1'b1;
        end
    end

endmodule

// File: rtl/bcfg_regs.sv
module bcfg_regs
    import bcfg_pkg::*;
#(
    parameter bit IO_32BIT         = 1'b1,
    parameter bit PREF_64BIT       = 1'b1,
    parameter bit FWD_OFF_AT_RESET = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  bcfg_we_t    we,
    input  logic [31:0] wdata,
    output bcfg_regs_t  regs
);

    localparam logic [3:0]  RST_BASE4  = FWD_OFF_AT_RESET ? 4'hF : 4'h0;
    localparam logic [11:0] RST_BASE12 = FWD_OFF_AT_RESET ? 12'hFFF : 12'h000;

    logic [7:0]  pri_bus_q, sec_bus_q, sub_bus_q, sec_lat_q;
    logic [3:0]  io_base_q, io_lim_q;
    logic [11:0] mem_base_q, mem_lim_q, pref_base_q, pref_lim_q;
    logic [15:0] brctl_q;
    logic [31:0] pref_ub_q, pref_ul_q;
    logic [15:0] io_bu_q, io_lu_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_bus_q   <= '0;
            sec_bus_q   <= '0;
            sub_bus_q   <= '0;
            sec_lat_q   <= '0;
            io_base_q   <= RST_BASE4;
            io_lim_q    <= '0;
            mem_base_q  <= RST_BASE12;
            mem_lim_q   <= '0;
            pref_base_q <= RST_BASE12;
            pref_lim_q  <= '0;
            brctl_q     <= '0;
        end else begin
            if (we.bus[0])   pri_bus_q          <= wdata[7:0];
            if (we.bus[1])   sec_bus_q          <= wdata[15:8];
            if (we.bus[2])   sub_bus_q          <= wdata[23:16];
            if (we.bus[3])   sec_lat_q          <= wdata[31:24];
            if (we.io[0])    io_base_q          <= wdata[7:4];
            if (we.io[1])    io_lim_q           <= wdata[15:12];
            if (we.mem[0])   mem_base_q[3:0]    <= wdata[7:4];
            if (we.mem[1])   mem_base_q[11:4]   <= wdata[15:8];
            if (we.mem[2])   mem_lim_q[3:0]     <= wdata[23:20];
            if (we.mem[3])   mem_lim_q[11:4]    <= wdata[31:24];
            if (we.pref[0])  pref_base_q[3:0]   <= wdata[7:4];
            if (we.pref[1])  pref_base_q[11:4]  <= wdata[15:8];
            if (we.pref[2])  pref_lim_q[3:0]    <= wdata[23:20];
            if (we.pref[3])  pref_lim_q[11:4]   <= wdata[31:24];
            if (we.brctl[0]) brctl_q[7:0]       <= wdata[23:16];
            if (we.brctl[1]) brctl_q[15:8]      <= wdata[31:24];
        end
    end

    generate
        if (PREF_64BIT) begin : g_pref_up
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pref_ub_q <= '0;
                    pref_ul_q <= '0;
                end else begin
                    for (int b = 0; b < 4; b++) begin
                        if (we.pref_ub[b]) pref_ub_q[8*b +: 8] <= wdata[8*b +: 8];
                        if (we.pref_ul[b]) pref_ul_q[8*b +: 8] <= wdata[8*b +: 8];
                    end
                end
            end
        end else begin : g_pref_noup
            assign pref_ub_q = '0;
            assign pref_ul_q = '0;
        end

        if (IO_32BIT) begin : g_io_up
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    io_bu_q <= '0;
                    io_lu_q <= '0;
                end else begin
                    if (we.io_up[0]) io_bu_q[7:0]  <= wdata[7:0];
                    if (we.io_up[1]) io_bu_q[15:8] <= wdata[15:8];
                    if (we.io_up[2]) io_lu_q[7:0]  <= wdata[23:16];
                    if (we.io_up[3]) io_lu_q[15:8] <= wdata[31:24];
                end
            end
        end else begin : g_io_noup
            assign io_bu_q = '0;
            assign io_lu_q = '0;
        end
    endgenerate

    always_comb begin
        regs.pri_bus       = pri_bus_q;
        regs.sec_bus       = sec_bus_q;
        regs.sub_bus       = sub_bus_q;
        regs.sec_lat       = sec_lat_q;
        regs.io_base_rng   = io_base_q;
        regs.io_lim_rng    = io_lim_q;
        regs.mem_base_rng  = mem_base_q;
        regs.mem_lim_rng   = mem_lim_q;
        regs.pref_base_rng = pref_base_q;
        regs.pref_lim_rng  = pref_lim_q;
        regs.pref_base_up  = pref_ub_q;
        regs.pref_lim_up   = pref_ul_q;
        regs.io_base_up    = io_bu_q;
        regs.io_lim_up     = io_lu_q;
        regs.brctl         = brctl_q;
    end

endmodule

// File: rtl/bcfg_srst_fsm.sv
module bcfg_srst_fsm
    import bcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_wbit,
    input  logic ctl_cur,
    output logic pulse
);

    srst_state_e state_q, state_d;
    logic        bit_next;

    assign bit_next = ctl_we ? ctl_wbit : ctl_cur;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  if (bit_next && !ctl_cur) state_d = SR_PULSE;
            SR_PULSE: state_d = bit_next ? SR_HOLD : SR_IDLE;
            SR_HOLD:  if (!bit_next) state_d = SR_IDLE;
            default:  state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            SR_PULSE: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcfg_rd_mux.sv
module bcfg_rd_mux
    import bcfg_pkg::*;
#(
    parameter bit IO_32BIT   = 1'b1,
    parameter bit PREF_64BIT = 1'b1,
    parameter bit MULTI_FUNC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [DW_AW-1:0] rd_addr,
    input  bcfg_regs_t       regs,
    output logic [31:0]      rdata,
    output logic             rvalid
);

    localparam logic [3:0] IO_TYPE   = IO_32BIT   ? 4'h1 : 4'h0;
    localparam logic [3:0] PREF_TYPE = PREF_64BIT ? 4'h1 : 4'h0;

    logic [31:0] rd_word;

    always_comb begin
        rd_word = '0;
        unique case (rd_addr)
            DW_CMDSTS:  rd_word = {STATUS_CAPS, 16'h0000};
            DW_CLASS:   rd_word = {CLASS_P2P, 8'h00};
            DW_HDR:     rd_word = {8'h00, MULTI_FUNC, HDR_BRIDGE, 16'h0000};
            DW_BUSNUM:  rd_word = {regs.sec_lat, regs.sub_bus, regs.sec_bus, regs.pri_bus};
            DW_IOSTS:   rd_word = {STATUS_CAPS, regs.io_lim_rng, IO_TYPE,
                                   regs.io_base_rng, IO_TYPE};
            DW_MEM:     rd_word = {regs.mem_lim_rng, 4'h0, regs.mem_base_rng, 4'h0};
            DW_PREF:    rd_word = {regs.pref_lim_rng, PREF_TYPE,
                                   regs.pref_base_rng, PREF_TYPE};
            DW_PREF_UB: rd_word = regs.pref_base_up;
            DW_PREF_UL: rd_word = regs.pref_lim_up;
            DW_IO_UP:   rd_word = {regs.io_lim_up, regs.io_base_up};
            DW_BRCTL:   rd_word = {regs.brctl, 16'h0000};
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_req;
            if (rd_req) rdata <= rd_word;
        end
    end

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcfg_pkg::*;
#(
    parameter bit IO_32BIT         = 1'b1,
    parameter bit PREF_64BIT       = 1'b1,
    parameter bit MULTI_FUNC       = 1'b0,
    parameter bit FWD_OFF_AT_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_req,
    input  logic             cfg_we,
    input  logic [DW_AW-1:0] cfg_addr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             cfg_rvalid,
    output logic             win_update,
    output logic             sec_bus_rst
);

    bcfg_we_t   we;
    logic       win_hit;
    bcfg_regs_t regs;

    bcfg_wr_decode u_dec (
        .cfg_req (cfg_req),
        .cfg_we  (cfg_we),
        .cfg_addr(cfg_addr),
        .cfg_be  (cfg_be),
        .we      (we),
        .win_hit (win_hit)
    );

    bcfg_regs #(
        .IO_32BIT        (IO_32BIT),
        .PREF_64BIT      (PREF_64BIT),
        .FWD_OFF_AT_RESET(FWD_OFF_AT_RESET)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .wdata(cfg_wdata),
        .regs (regs)
    );

    bcfg_srst_fsm u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (we.brctl[0]),
        .ctl_wbit(cfg_wdata[16+SRST_BIT]),
        .ctl_cur (regs.brctl[SRST_BIT]),
        .pulse   (sec_bus_rst)
    );

    bcfg_rd_mux #(
        .IO_32BIT  (IO_32BIT),
        .PREF_64BIT(PREF_64BIT),
        .MULTI_FUNC(MULTI_FUNC)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (cfg_req && !cfg_we),
        .rd_addr(cfg_addr),
        .regs   (regs),
        .rdata  (cfg_rdata),
        .rvalid (cfg_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_update <= 1'b0;
        else        win_update <= win_hit;
    end

endmodule

// File: rtl/bridge_cfg_regs_chk.sv
module bridge_cfg_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_req,
    input logic cfg_we,
    input logic cfg_rvalid,
    input logic win_update,
    input logic sec_bus_rst
);

    p_srst_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |=> !sec_bus_rst);

    p_srst_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |-> $past(cfg_req && cfg_we));

    p_winupd_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_update |-> $past(cfg_req && cfg_we));

    p_read_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we) |=> (!win_update && !sec_bus_rst));

    p_read_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we) |=> cfg_rvalid);

    p_valid_only_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_req && !cfg_we));

endmodule

bind bridge_cfg_regs bridge_cfg_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_req    (cfg_req),
    .cfg_we     (cfg_we),
    .cfg_rvalid (cfg_rvalid),
    .win_update (win_update),
    .sec_bus_rst(sec_bus_rst)
);

// File: tb/bridge_cfg_regs_tb.sv
module bridge_cfg_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        rvalid_a, rvalid_b, wu_a, wu_b, sr_a, sr_b;

    int checks = 0;
    int errors = 0;
    logic [31:0] ra, rb;
    logic        rva;
    logic        lwu_a, lwu_b, lsr_a, lsr_b;

    always #4 clk = ~clk;

    bridge_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_a), .cfg_rvalid(rvalid_a),
        .win_update(wu_a), .sec_bus_rst(sr_a)
    );

    bridge_cfg_regs #(
        .IO_32BIT(1'b0), .PREF_64BIT(1'b0), .MULTI_FUNC(1'b1), .FWD_OFF_AT_RESET(1'b1)
    ) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_b), .cfg_rvalid(rvalid_b),
        .win_update(wu_b), .sec_bus_rst(sr_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0; cfg_be = '0;
        lwu_a = wu_a; lwu_b = wu_b; lsr_a = sr_a; lsr_b = sr_b;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        @(negedge clk);
        cfg_req = 1'b0;
        ra = rdata_a; rb = rdata_b; rva = rvalid_a;
        lwu_a = wu_a; lsr_a = sr_a;
    endtask

    task automatic t_reset;
        rd(6'd6);  chk("R1 busnum", ra, 32'h0); chk("R1 busnum alt", rb, 32'h0);
        chk("R10 rvalid", {31'b0, rva}, 32'h1);
        chk("R11 no strobe on read", {30'b0, lwu_a, lsr_a}, 32'h0);
        rd(6'd7);  chk("R2 io", ra, 32'h00A00101); chk("R3 io alt", rb, 32'h00A000F0);
        rd(6'd8);  chk("R2 mem", ra, 32'h0);       chk("R3 mem alt", rb, 32'h0000FFF0);
        rd(6'd9);  chk("R2 pref", ra, 32'h00010001); chk("R3 pref alt", rb, 32'h0000FFF0);
        rd(6'd10); chk("R2 pref upper base", ra, 32'h0); chk("R3 pref upper alt", rb, 32'h0);
        rd(6'd11); chk("R2 pref upper limit", ra, 32'h0);
        rd(6'd12); chk("R2 io upper", ra, 32'h0);
        rd(6'd15); chk("R2 brctl", ra, 32'h0);
    endtask

    task automatic t_identity;
        wr(6'd2, 4'hF, 32'hFFFFFFFF);
        wr(6'd3, 4'hF, 32'hFFFFFFFF);
        wr(6'd1, 4'hC, 32'hFFFFFFFF);
        rd(6'd2); chk("R8 class", ra, 32'h06040000);
        rd(6'd3); chk("R8 header", ra, 32'h00010000); chk("R8 header mf", rb, 32'h00810000);
        rd(6'd1); chk("R9 primary status", ra, 32'h00A00000);
        rd(6'd14); chk("R10 unimplemented", ra, 32'h0);
        rd(6'd63); chk("R10 unimplemented top", rb, 32'h0);
    endtask

    task automatic t_bytes;
        wr(6'd6, 4'b0101, 32'hAABBCCDD);
        rd(6'd6); chk("R4 partial be", ra, 32'h00BB00DD);
        wr(6'd6, 4'b1010, 32'h11223344);
        rd(6'd6); chk("R4 other bytes", ra, 32'h11BB33DD);
        wr(6'd7, 4'hF, 32'hFFFFFFFF);
        rd(6'd7); chk("R4 io type ro", ra, 32'h00A0F1F1);
        chk("R9 secondary status", ra[31:16], 32'h00A0); chk("R4 io alt", rb, 32'h00A0F0F0);
        wr(6'd8, 4'hF, 32'hFFFFFFFF);
        rd(6'd8); chk("R4 mem", ra, 32'hFFF0FFF0);
        wr(6'd9, 4'b0011, 32'hFFFFFFFF);
        rd(6'd9); chk("R4 pref base only", ra, 32'h0001FFF1); chk("R4 pref alt", rb, 32'h0000FFF0);
    endtask

    task automatic t_uppers;
        wr(6'd10, 4'hF, 32'h12345678);
        wr(6'd11, 4'hF, 32'h9ABCDEF0);
        wr(6'd12, 4'hF, 32'hDEADBEEF);
        rd(6'd10); chk("R5 pref ub", ra, 32'h12345678); chk("R5 pref ub alt", rb, 32'h0);
        rd(6'd11); chk("R5 pref ul", ra, 32'h9ABCDEF0);
        rd(6'd12); chk("R5 io up", ra, 32'hDEADBEEF); chk("R5 io up alt", rb, 32'h0);
    endtask

    task automatic t_srst;
        wr(6'd15, 4'b1000, 32'h00400000);
        chk("R6 byte2 disabled", {31'b0, lsr_a}, 32'h0);
        wr(6'd15, 4'b0100, 32'h00400000);
        chk("R6 rising", {30'b0, lsr_a, lsr_b}, 32'h3);
        @(negedge clk);
        chk("R6 one cycle", {31'b0, sr_a}, 32'h0);
        wr(6'd15, 4'b0100, 32'h00400000);
        chk("R6 already set", {31'b0, lsr_a}, 32'h0);
        rd(6'd15); chk("R6 brctl value", ra, 32'h00400000);
        wr(6'd15, 4'b0100, 32'h00000000);
        chk("R6 clear", {31'b0, lsr_a}, 32'h0);
        wr(6'd15, 4'b1100, 32'h00480000);
        chk("R6 rising again", {31'b0, lsr_a}, 32'h1);
    endtask

    task automatic t_winupd;
        wr(6'd1, 4'b0001, 32'h6); chk("R7 command", {31'b0, lwu_a}, 32'h1);
        wr(6'd1, 4'b1100, 32'h0); chk("R7 status no", {31'b0, lwu_a}, 32'h0);
        wr(6'd7, 4'b0100, 32'h0); chk("R7 sec status no", {31'b0, lwu_a}, 32'h0);
        wr(6'd7, 4'b0010, 32'h0); chk("R7 io limit", {31'b0, lwu_b}, 32'h1);
        wr(6'd6, 4'hF, 32'h0);    chk("R7 busnum no", {31'b0, lwu_a}, 32'h0);
        wr(6'd13, 4'hF, 32'h0);   chk("R7 past span no", {31'b0, lwu_a}, 32'h0);
        wr(6'd12, 4'b1000, 32'h0); chk("R7 io upper", {31'b0, lwu_a}, 32'h1);
        wr(6'd8, 4'b0000, 32'h0); chk("R7 no bytes", {31'b0, lwu_a}, 32'h0);
        wr(6'd15, 4'b0011, 32'h0); chk("R7 int line no", {31'b0, lwu_a}, 32'h0);
        wr(6'd15, 4'b1000, 32'h0); chk("R7 brctl", {31'b0, lwu_a}, 32'h1);
        @(negedge clk);
        chk("R7 one cycle", {31'b0, wu_a}, 32'h0);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_identity();
        t_bytes();
        t_uppers();
        t_srst();
        t_winupd();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule